// File: doc/BRIEF.md
# Parallel Flash Erase Sequencer

This block runs erase commands on a bank of four byte-wide parallel flash devices that share one 32-bit data bus. Each device owns one byte lane. A single start pulse launches either a whole-device erase or an erase of a sector-aligned address range. A chip-type input picks the sector size and the command strategy. The small-sector type needs a full command and a completion wait for each sector. The large-sector type takes every sector address of the range under one command and then waits once. A 4-bit select keeps the unlock pattern off the byte lanes of devices that should be left alone.

The block drives the bus only through an abstract request interface. Each request is one write cycle or one read cycle, and it is held until it is acknowledged. The block detects that an erase has finished by reading address 0 until two reads in a row agree. When the operation ends, the block gives a one-cycle done pulse. The pulse carries a success bit and a misalignment flag.

Top module: `flash_erase_seq`

## Requirements
- R1: A whole-device erase (`whole_chip`=1) issues exactly six writes, in this order: U1, U2, 0x80808080 to UA, U1, U2, 0x10101010 to UA. A completion poll then follows. The address and length inputs are ignored.
- R2: The unlock address UA is 0x55555555 for the small-sector type (`big_sector`=0) and 0xAAAAAAAA for the large-sector type. Unlock write U1 puts data 0xAAAAAAAA at UA. Unlock write U2 puts data 0x55555555 at the bitwise complement of UA.
- R3: In U1 and U2 only, data lane i (bits 8i+7..8i) keeps its pattern when `chip_sel[i]`=1 and is zero otherwise. The 0x80, 0x10 and 0x30 command words are never masked.
- R4: For a range erase, the sector size is 4096 bytes for the small type and 65536 bytes for the large type. If the start address or the length is not a multiple of that size, the result is done with `done_ok`=0 and `done_misalign`=1, and no bus request is made.
- R5: A small-type range erase handles each sector in ascending order. For each sector it issues U1, U2, 0x80808080 to UA, U1, U2, then 0x30303030 to the sector address, and it completes a poll before the next sector starts.
- R6: A large-type range erase issues one prefix (U1, U2, 0x80808080 to UA, U1, U2). It then writes 0x30303030 to each 64 KB sector address in ascending order, and finishes with a single poll.
- R7: A large-type range that starts at address 0 covers its first 64 KB with writes of 0x30303030 to 0x0000, 0x4000, 0x6000 and 0x8000, in that order. It then continues at 0x10000.
- R8: A poll reads address 0 repeatedly. It ends at the first read whose data equals the data of the read just before it. When the last poll of an operation ends this way, done pulses with `done_ok`=1.
- R9: If a poll makes POLL_MAX reads with no equal pair, the operation is abandoned and no further requests are made. Done pulses with `done_ok`=0 and `done_misalign`=0.
- R10: A range erase with length 0 and an aligned address ends with done and `done_ok`=1, and makes no bus request.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` keep their values into the next cycle. A request completes in each cycle in which both are high.
- R12: `busy` is high from the cycle after an accepted start until the done pulse, and it is low during that pulse. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation (sampled when idle) |
| whole_chip | input | 1 | 1: whole-device erase, 0: range erase |
| big_sector | input | 1 | Chip type: 0 small 4 KB sectors, 1 large 64 KB sectors |
| chip_sel | input | 4 | Per-device select for the unlock pattern, bit i = lane i |
| erase_addr | input | 32 | Range start address |
| erase_len | input | 32 | Range length in bytes |
| bus_req | output | 1 | Bus cycle requested |
| bus_we | output | 1 | 1: write cycle, 0: read cycle |
| bus_addr | output | 32 | Cycle address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Request accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack on a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_ok | output | 1 | Success, valid with done |
| done_misalign | output | 1 | Alignment rejection, valid with done |

## Verification
A wrong step counter or unlock address shows up at the very next acknowledged write as a mismatched address or data word. For that reason, every acknowledged cycle is compared against an ordered list of expected cycles built from the requirements. A wrong remaining-length or boot-index state shows up later, as a missing or extra 0x30 write, or as a poll started one sector too early. Running the range tests with several sector counts and with a start at 0 exposes those errors within one sector. Poll-counter faults show up only as a wrong read count or a wrong success bit at done. The bench therefore varies how long the read data keeps toggling, and includes one run that exceeds POLL_MAX.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int POLL_MAX   = 64,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        whole_chip,
  input  logic        big_sector,
  input  logic [3:0]  chip_sel,
  input  logic [31:0] erase_addr,
  input  logic [31:0] erase_len,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        busy,
  output logic        done,
  output logic        done_ok,
  output logic        done_misalign
);

  localparam int PW = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1;
  localparam logic [31:0] SM_SZ = 32'(1) << SMALL_LOG2;
  localparam logic [31:0] LG_SZ = 32'(1) << LARGE_LOG2;
  localparam logic [31:0] UA_SM = 32'h5555_5555;
  localparam logic [31:0] UA_LG = 32'hAAAA_AAAA;
  localparam logic [31:0] PAT_A = 32'hAAAA_AAAA;
  localparam logic [31:0] PAT_5 = 32'h5555_5555;
  localparam logic [31:0] CMD_SETUP = 32'h8080_8080;
  localparam logic [31:0] CMD_WHOLE = 32'h1010_1010;
  localparam logic [31:0] CMD_SECT  = 32'h3030_3030;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_POLL} st_t;

  st_t         st;
  logic [2:0]  step;
  logic        whole_q, big_q, in_boot, have_prev;
  logic [1:0]  bidx;
  logic [31:0] lmask, cur, remain, prev;
  logic [PW-1:0] pcnt;
  logic        done_q, ok_q, mis_q;

  logic [31:0] ua, sect, sect_in, boot_off, wr_addr, wr_data, tgt;
  logic        misalign, poll_match, more_small;

  assign ua       = big_q ? UA_LG : UA_SM;
  assign sect     = big_q ? LG_SZ : SM_SZ;
  assign sect_in  = big_sector ? LG_SZ : SM_SZ;
  assign misalign = !whole_chip && (((erase_addr | erase_len) & (sect_in - 32'd1)) != 32'd0);

  always_comb begin
    case (bidx)
      2'd0:    boot_off = 32'h0000_0000;
      2'd1:    boot_off = 32'h0000_4000;
      2'd2:    boot_off = 32'h0000_6000;
      default: boot_off = 32'h0000_8000;
    endcase
  end

  assign tgt = in_boot ? boot_off : cur;

  always_comb begin
    case (step)
      3'd0, 3'd3: begin wr_addr = ua;  wr_data = PAT_A & lmask; end
      3'd1, 3'd4: begin wr_addr = ~ua; wr_data = PAT_5 & lmask; end
      3'd2:       begin wr_addr = ua;  wr_data = CMD_SETUP; end
      default:    begin
        wr_addr = whole_q ? ua : tgt;
        wr_data = whole_q ? CMD_WHOLE : CMD_SECT;
      end
    endcase
  end

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = (st == S_WR) ? wr_addr : 32'd0;
  assign bus_wdata = (st == S_WR) ? wr_data : 32'd0;
  assign busy      = (st != S_IDLE);
  assign done          = done_q;
  assign done_ok       = ok_q;
  assign done_misalign = mis_q;

  assign poll_match = have_prev && (bus_rdata == prev);
  assign more_small = !whole_q && !big_q && (remain != 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; whole_q <= 1'b0; big_q <= 1'b0;
      in_boot <= 1'b0; bidx <= '0; lmask <= '0; cur <= '0; remain <= '0;
      prev <= '0; have_prev <= 1'b0; pcnt <= '0;
      done_q <= 1'b0; ok_q <= 1'b0; mis_q <= 1'b0;
    end else begin
      done_q <= 1'b0; ok_q <= 1'b0; mis_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (misalign) begin
            done_q <= 1'b1; mis_q <= 1'b1;
          end else if (!whole_chip && erase_len == 32'd0) begin
            done_q <= 1'b1; ok_q <= 1'b1;
          end else begin
            st      <= S_WR;
            step    <= '0;
            whole_q <= whole_chip;
            big_q   <= big_sector;
            lmask   <= {{8{chip_sel[3]}}, {8{chip_sel[2]}}, {8{chip_sel[1]}}, {8{chip_sel[0]}}};
            cur     <= erase_addr;
            remain  <= erase_len;
            in_boot <= big_sector && !whole_chip && erase_addr == 32'd0;
            bidx    <= '0;
          end
        end
        S_WR: begin
          have_prev <= 1'b0;
          pcnt      <= '0;
          if (bus_ack) begin
            if (step != 3'd5) begin
              step <= step + 3'd1;
            end else if (whole_q) begin
              st <= S_POLL;
            end else if (!big_q) begin
              st     <= S_POLL;
              cur    <= cur + sect;
              remain <= remain - sect;
            end else if (in_boot && bidx != 2'd3) begin
              bidx <= bidx + 2'd1;
            end else begin
              in_boot <= 1'b0;
              cur     <= cur + sect;
              remain  <= remain - sect;
              if (remain == sect) st <= S_POLL;
            end
          end
        end
        S_POLL: if (bus_ack) begin
          prev      <= bus_rdata;
          have_prev <= 1'b1;
          if (poll_match) begin
            if (more_small) begin
              st <= S_WR; step <= '0;
            end else begin
              st <= S_IDLE; done_q <= 1'b1; ok_q <= 1'b1;
            end
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            st <= S_IDLE; done_q <= 1'b1;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  a_r8_poll_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> bus_addr == 32'd0);

  a_r4_misalign_fails: assert property (@(posedge clk) disable iff (!rst_n)
    done_misalign |-> done && !done_ok);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r12_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PMAX = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, whole_chip = 1'b0, big_sector = 1'b0;
  logic [3:0] chip_sel = 4'hF;
  logic [31:0] erase_addr = '0, erase_len = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic busy, done, done_ok, done_misalign;

  int checks = 0, errors = 0, cyc = 0, tog_k = 0, tog_left = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [64:0] expq[$];
  bit prev_stall = 0;
  logic [64:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(.POLL_MAX(PMAX)) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .whole_chip(whole_chip),
    .big_sector(big_sector), .chip_sel(chip_sel), .erase_addr(erase_addr),
    .erase_len(erase_len), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .done_ok(done_ok),
    .done_misalign(done_misalign));

  task automatic chk(bit cond, string req, string what, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic a;
    logic [64:0] e;
    cyc++;
    if (prev_stall)
      chk(bus_req && {bus_we, bus_addr, bus_wdata} == held, "R11", "held request",
          {bus_we, bus_addr, bus_wdata}, held);
    a = bus_req && (cyc % 4 != 3);
    prev_stall = bus_req && !a;
    held = {bus_we, bus_addr, bus_wdata};
    bus_ack <= a;
    if (a) begin
      if (expq.size() == 0) begin
        chk(0, cur_req, "unexpected cycle", {bus_we, bus_addr, bus_wdata}, '0);
      end else begin
        e = expq.pop_front();
        if (e[64]) chk(bus_we && bus_addr == e[63:32] && bus_wdata == e[31:0], cur_req,
                       "write", {bus_we, bus_addr, bus_wdata}, e);
        else chk(!bus_we && bus_addr == e[63:32], cur_req, "read",
                 {bus_we, bus_addr, 32'd0}, {1'b0, e[63:32], 32'd0});
      end
      if (bus_we) tog_left = tog_k;
      else begin
        bus_rdata <= (tog_left > 0) ? ((tog_left % 2) ? 32'h4040_4040 : 32'h0) : 32'hFFFF_FFFF;
        if (tog_left > 0) tog_left--;
      end
    end
  end

  function automatic void pw(logic [31:0] a, logic [31:0] d);
    expq.push_back({1'b1, a, d});
  endfunction

  function automatic bit pollq(int k);
    int n = (k + 2 <= PMAX) ? k + 2 : PMAX;
    for (int i = 0; i < n; i++) expq.push_back({1'b0, 32'd0, 32'd0});
    return (k + 2 <= PMAX);
  endfunction

  function automatic void prefix(logic [31:0] ua, logic [31:0] lm);
    pw(ua, 32'hAAAA_AAAA & lm); pw(~ua, 32'h5555_5555 & lm);
    pw(ua, 32'h8080_8080);
    pw(ua, 32'hAAAA_AAAA & lm); pw(~ua, 32'h5555_5555 & lm);
  endfunction

  task automatic run_op(bit wc, bit bs, logic [3:0] sel, logic [31:0] ad, logic [31:0] ln,
                        int k, string req, bit poke);
    logic [31:0] ua = bs ? 32'hAAAA_AAAA : 32'h5555_5555;
    logic [31:0] lm = {{8{sel[3]}}, {8{sel[2]}}, {8{sel[1]}}, {8{sel[0]}}};
    logic [31:0] sz = bs ? 32'h1_0000 : 32'h1000;
    bit eok = 1, emis = 0;
    int n = 0;
    expq.delete();
    cur_req = req;
    tog_k = k;
    if (wc) begin
      prefix(ua, lm); pw(ua, 32'h1010_1010); eok = pollq(k);
    end else if ((ad % sz) != 0 || (ln % sz) != 0) begin
      eok = 0; emis = 1;
    end else if (ln != 0) begin
      if (!bs) begin
        for (longint a = ad; a < longint'(ad) + ln; a += sz) begin
          prefix(ua, lm); pw(a[31:0], 32'h3030_3030);
          eok = pollq(k);
          if (!eok) break;
        end
      end else begin
        longint a = ad;
        prefix(ua, lm);
        if (ad == 0) begin
          pw(32'h0, 32'h3030_3030); pw(32'h4000, 32'h3030_3030);
          pw(32'h6000, 32'h3030_3030); pw(32'h8000, 32'h3030_3030);
          a = 32'h1_0000;
        end
        for (; a < longint'(ad) + ln; a += sz) pw(a[31:0], 32'h3030_3030);
        eok = pollq(k);
      end
    end
    @(negedge clk);
    whole_chip = wc; big_sector = bs; chip_sel = sel; erase_addr = ad; erase_len = ln;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!wc && emis == 0 && ln != 0) chk(busy, "R12", "busy after start", {64'd0, busy}, 65'd1);
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        start = 1'b1; whole_chip = 1'b1; big_sector = ~bs; chip_sel = 4'h0;
      end
      if (poke && n == 6) start = 1'b0;
    end
    chk(done, req, "done seen", {64'd0, done}, 65'd1);
    chk(done_ok == eok, req, "done_ok", {64'd0, done_ok}, {64'd0, eok});
    chk(done_misalign == emis, emis ? "R4" : req, "done_misalign", {64'd0, done_misalign}, {64'd0, emis});
    chk(!busy, "R12", "busy low at done", {64'd0, busy}, 65'd0);
    chk(expq.size() == 0, req, "missing cycles", 65'(expq.size()), 65'd0);
    repeat (3) @(negedge clk);
    chk(!bus_req && !busy, req, "quiet after done", {63'd0, bus_req, busy}, 65'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req, "R12", "reset state", {62'd0, busy, done, bus_req}, 65'd0);
    rst_n = 1'b1;
    run_op(1, 0, 4'hF, 32'h0, 32'h0, 3, "R1", 0);
    run_op(1, 1, 4'h5, 32'h1234, 32'h77, 2, "R3", 0);
    run_op(0, 0, 4'h3, 32'h0, 32'h1000, 0, "R2", 0);
    run_op(0, 0, 4'hF, 32'h3000, 32'h2000, 1, "R5", 0);
    run_op(0, 0, 4'h9, 32'h8000, 32'h3000, 5, "R8", 0);
    run_op(0, 0, 4'hF, 32'h100, 32'h1000, 0, "R4", 0);
    run_op(0, 1, 4'hF, 32'h1_0000, 32'h1000, 0, "R4", 0);
    run_op(0, 1, 4'hA, 32'h2_0000, 32'h2_0000, 4, "R6", 0);
    run_op(0, 1, 4'hF, 32'h0, 32'h3_0000, 0, "R7", 0);
    run_op(0, 1, 4'hC, 32'h0, 32'h1_0000, 1, "R7", 0);
    run_op(0, 0, 4'hF, 32'h5000, 32'h0, 0, "R10", 0);
    run_op(1, 0, 4'hF, 32'h0, 32'h0, 100, "R9", 0);
    run_op(0, 0, 4'h6, 32'h1000, 32'h1000, 2, "R12", 1);
    run_op(0, 0, 4'hF, 32'h4000, 32'h2000, 100, "R9", 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule